// File: doc/BRIEF.md
# Dual-Slope Conversion Phase Sequencer

This block runs an external dual-slope integrating A/D converter through one conversion after another. It drives a two-bit phase code that puts the converter into auto-zero, signal integrate, de-integrate and integrator-zero in that order. A single timer on the system clock sets the length of each fixed phase and measures the length of the de-integrate phase.

The converter's zero-crossing comparator output enters the block through a two-flop synchronizer. The block uses it in two places. Its synchronized level in the final integrate cycle gives the input polarity. A falling edge of it during de-integrate ends the measurement. If no falling edge arrives before the de-integrate timer reaches its full-scale limit, the block flags overrange and stops de-integrate. At the end of every de-integrate phase the block writes the magnitude count, the overrange flag and the polarity flag together into the result register, and it raises a one-cycle valid pulse.

Top module: `dslope_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, the phase code is auto-zero (`phase_a`=0, `phase_b`=1). `res_valid` is 0 and the result fields are all zero.
- R2: The phase code `{phase_a,phase_b}` follows 01 (auto-zero) → 10 (integrate) → 11 (de-integrate) → 00 (integrator-zero) → 01 and repeats. No other transition occurs.
- R3: Auto-zero lasts exactly `AZ_CYC` clock cycles, integrate lasts exactly `INT_CYC` cycles and integrator-zero lasts exactly `IZ_CYC` cycles.
- R4: `res_pol` gets the synchronized comparator level of the final integrate cycle: 1 means a positive input and 0 a negative one. For `res_pol` to be 1, `cmp_in` must be high at the two rising edges before the end of integrate.
- R5: Number the rising edges after de-integrate begins from 1. If `cmp_in` falls and is first sampled low at edge j, then de-integrate lasts j+2 cycles and `res_count` = j+1 with `res_ovr` = 0. This holds provided j+1 ≤ `DINT_MAX`.
- R6: If no synchronized falling edge occurs by the time the de-integrate timer reaches `DINT_MAX`, then de-integrate lasts `DINT_MAX`+1 cycles, `res_count` = `DINT_MAX` and `res_ovr` = 1. A falling edge seen in the same cycle that the timer reaches `DINT_MAX` counts as a normal end (`res_ovr` = 0).
- R7: `res_valid` is high for exactly one cycle: the first cycle of integrator-zero after each de-integrate. The count, the overrange flag and the polarity flag all change in that cycle and stay unchanged at all other times.
- R8: Comparator falling edges during auto-zero, integrate or integrator-zero have no effect on the phase lengths or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_in | input | 1 | Zero-crossing comparator level from the converter (asynchronous) |
| phase_a | output | 1 | High bit of the converter phase code |
| phase_b | output | 1 | Low bit of the converter phase code |
| res_count | output | CNT_W | De-integrate magnitude count |
| res_ovr | output | 1 | Overrange flag |
| res_pol | output | 1 | Polarity flag, 1 = positive input |
| res_valid | output | 1 | One-cycle pulse when a new result is written |

## Verification
The bench builds the block with `AZ_CYC`=5, `INT_CYC`=7, `IZ_CYC`=3 and `DINT_MAX`=20. With these values a whole conversion takes only a few dozen cycles. This lets the bench sweep the comparator drop point across every de-integrate cycle, from the first cycle past the full-scale limit. The sweep covers the tie, where the edge arrives in the same cycle the limit is reached, and both cases just beyond it. Separate runs hold the comparator low for a negative input and glitch it during auto-zero and integrate.

// File: rtl/dslope_sequencer.sv
module dslope_sequencer #(
  parameter int CNT_W    = 16,
  parameter int AZ_CYC   = 1000,
  parameter int INT_CYC  = 4000,
  parameter int IZ_CYC   = 200,
  parameter int DINT_MAX = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_in,
  output logic             phase_a,
  output logic             phase_b,
  output logic [CNT_W-1:0] res_count,
  output logic             res_ovr,
  output logic             res_pol,
  output logic             res_valid
);

  localparam int M1   = (AZ_CYC > INT_CYC) ? AZ_CYC : INT_CYC;
  localparam int M2   = (IZ_CYC > DINT_MAX) ? IZ_CYC : DINT_MAX;
  localparam int LMAX = (M1 > M2) ? M1 : M2;
  localparam int TW   = $clog2(LMAX + 1);

  localparam logic [1:0] PH_AZ   = 2'b01;
  localparam logic [1:0] PH_INT  = 2'b10;
  localparam logic [1:0] PH_DINT = 2'b11;
  localparam logic [1:0] PH_IZ   = 2'b00;

  logic [1:0]    ph;
  logic [TW-1:0] tmr;
  logic          sy_meta, sy_lvl, sy_old;
  logic          pol_q;

  wire fall     = sy_old & ~sy_lvl;
  wire last_az  = (tmr == TW'(AZ_CYC - 1));
  wire last_int = (tmr == TW'(INT_CYC - 1));
  wire last_iz  = (tmr == TW'(IZ_CYC - 1));
  wire at_limit = (tmr == TW'(DINT_MAX));

  assign phase_a = ph[1];
  assign phase_b = ph[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy_meta <= 1'b0;
      sy_lvl  <= 1'b0;
      sy_old  <= 1'b0;
    end else begin
      sy_meta <= cmp_in;
      sy_lvl  <= sy_meta;
      sy_old  <= sy_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph        <= PH_AZ;
      tmr       <= '0;
      pol_q     <= 1'b0;
      res_count <= '0;
      res_ovr   <= 1'b0;
      res_pol   <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (ph)
        PH_AZ: begin
          if (last_az) begin
            ph  <= PH_INT;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        PH_INT: begin
          if (last_int) begin
            ph    <= PH_DINT;
            tmr   <= '0;
            pol_q <= sy_lvl;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        PH_DINT: begin
          if (fall || at_limit) begin
            ph        <= PH_IZ;
            tmr       <= '0;
            res_count <= CNT_W'(tmr);
            res_ovr   <= ~fall;
            res_pol   <= pol_q;
            res_valid <= 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          if (last_iz) begin
            ph  <= PH_AZ;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
      endcase
    end
  end

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != $past(ph)) |->
      (($past(ph) == PH_AZ   && ph == PH_INT)  ||
       ($past(ph) == PH_INT  && ph == PH_DINT) ||
       ($past(ph) == PH_DINT && ph == PH_IZ)   ||
       ($past(ph) == PH_IZ   && ph == PH_AZ)));

  p_fixed_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_AZ)  -> (tmr < TW'(AZ_CYC)))  &&
    ((ph == PH_INT) -> (tmr < TW'(INT_CYC))) &&
    ((ph == PH_IZ)  -> (tmr < TW'(IZ_CYC))));

  p_dint_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DINT) |-> (tmr <= TW'(DINT_MAX)));

  p_ovr_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ovr) |-> (res_count == CNT_W'(DINT_MAX)));

  p_valid_in_iz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (ph == PH_IZ && tmr == '0 && $past(ph) == PH_DINT));

  p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_count) && $stable(res_ovr) && $stable(res_pol)));

endmodule

// File: tb/dslope_sequencer_test.sv
module dslope_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 16;
  localparam int AZC  = 5;
  localparam int INTC = 7;
  localparam int IZC  = 3;
  localparam int DMAX = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmp_in = 1'b1;
  logic          phase_a, phase_b, res_ovr, res_pol, res_valid;
  logic [CW-1:0] res_count;

  int checks = 0;
  int fails  = 0;
  int exp_dint = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dslope_sequencer #(.CNT_W(CW), .AZ_CYC(AZC), .INT_CYC(INTC), .IZ_CYC(IZC), .DINT_MAX(DMAX)) uut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in),
    .phase_a(phase_a), .phase_b(phase_b),
    .res_count(res_count), .res_ovr(res_ovr), .res_pol(res_pol), .res_valid(res_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Phase monitor: order (R2), lengths (R3, R5, R6), valid placement (R7)
  logic [1:0] prev_ph = 2'b01;
  int run_len = 0;
  bit first = 1;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [1:0] cur;
      cur = {phase_a, phase_b};
      if (cur != prev_ph) begin
        chk((prev_ph == 2'b01 && cur == 2'b10) || (prev_ph == 2'b10 && cur == 2'b11) ||
            (prev_ph == 2'b11 && cur == 2'b00) || (prev_ph == 2'b00 && cur == 2'b01),
            "R2 phase order", cur, prev_ph);
        if (!first) begin
          case (prev_ph)
            2'b01: chk(run_len == AZC,  "R3 auto-zero length", run_len, AZC);
            2'b10: chk(run_len == INTC, "R3 integrate length", run_len, INTC);
            2'b00: chk(run_len == IZC,  "R3 integrator-zero length", run_len, IZC);
            default: chk(run_len == exp_dint, "R5/R6 de-integrate length", run_len, exp_dint);
          endcase
        end
        chk(res_valid == (cur == 2'b00), "R7 valid at phase entry", res_valid, cur == 2'b00);
        first = 0;
        prev_ph = cur;
        run_len = 1;
      end else begin
        chk(res_valid == 1'b0, "R7 valid outside first cycle of integrator-zero", res_valid, 0);
        run_len++;
      end
    end
  end

  task automatic wait_phase(input logic [1:0] p);
    while ({phase_a, phase_b} != p) @(negedge clk);
  endtask

  task automatic run_conv(input int k, input bit pol, input bit glitch);
    int ecount;
    bit eovr;
    wait_phase(2'b01);
    cmp_in = pol;
    if (glitch) begin
      @(negedge clk); cmp_in = 1'b0;
      @(negedge clk); @(negedge clk); cmp_in = pol;
      wait_phase(2'b10);
      @(negedge clk); cmp_in = 1'b0;
      @(negedge clk); @(negedge clk); cmp_in = pol;
    end
    if (!pol || k + 2 > DMAX) begin
      ecount = DMAX; eovr = 1; exp_dint = DMAX + 1;
    end else begin
      ecount = k + 2; eovr = 0; exp_dint = k + 3;
    end
    wait_phase(2'b11);
    for (int n = 0; n < 100; n++) begin
      if (pol && n == k) cmp_in = 1'b0;
      @(negedge clk);
      if (res_valid) break;
    end
    chk(res_valid == 1'b1, "R7 result produced", res_valid, 1);
    chk(int'(res_count) == ecount, eovr ? "R6 overrange count" : "R5 de-integrate count", res_count, ecount);
    chk(res_ovr == eovr, eovr ? "R6 overrange flag" : "R5 overrange clear", res_ovr, eovr);
    chk(res_pol == pol, glitch ? "R8/R4 polarity after glitches" : "R4 polarity", res_pol, pol);
    cmp_in = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({phase_a, phase_b} == 2'b01, "R1 reset phase", {phase_a, phase_b}, 1);
    chk(res_valid == 1'b0, "R1 reset valid", res_valid, 0);
    chk(res_count == '0 && !res_ovr && !res_pol, "R1 reset result", res_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({phase_a, phase_b} == 2'b01, "R1 first phase after reset", {phase_a, phase_b}, 1);
    for (int k = 0; k <= DMAX + 1; k++) run_conv(k, 1'b1, 1'b0);
    run_conv(0, 1'b0, 1'b0);
    run_conv(4, 1'b1, 1'b1);
    run_conv(DMAX - 2, 1'b1, 1'b1);
    run_conv(3, 1'b0, 1'b0);
    run_conv(7, 1'b1, 1'b0);
    wait_phase(2'b01);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule